// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Overflow Flag

This block is a register-mapped signed multiplier for 16-bit operands. Software writes the first operand to one of two addresses. The address it uses picks the operation: a plain signed product, or a signed product added to the running 32-bit result. Writing the second operand launches the operation. The new result, its sign-extension word and a status flag are stored at the next clock edge.

The result can be read back as a low half and a high half. The sign-extension word is all ones when the result is negative and all zeros otherwise. In accumulate mode the status flag is not a true carry. It follows the result sign while the sum stays in signed range. When the sum leaves that range, the sign-extension word keeps the true sign of the unwrapped sum and the flag takes its inverse. Software detects signed overflow by seeing the two disagree.

Both result halves can be written, so an accumulator start value can be loaded before a chain of accumulations. Writes go through one write port. Reads use a separate combinational read port that is driven straight from the registers.

Top module: `smac_unit`

## Requirements
- R1: While `rst` is high, the next clock edge clears the result, the sign-extension word and the flag, and selects plain multiply mode (status bit 1 = 0).
- R2: A write to address 0 stores operand 1 and selects plain multiply. A write to address 1 stores operand 1 and selects accumulate. The mode reads back in status bit 1, where 1 means accumulate.
- R3: A write to address 2 launches the operation. It uses the written value as operand 2, together with the stored operand 1 and mode. The outputs change at that clock edge and at no other.
- R4: In multiply mode the 32-bit result is the two's-complement product, for example 0xFFFA × 0x0005 = 0xFFFFFFE2.
- R5: In multiply mode, status bit 0 (the flag) equals result bit 31. The sign-extension word (address 5) is 0xFFFF for a negative result and 0x0000 otherwise.
- R6: In accumulate mode the product is added to the stored result, modulo 2^32. For example, 0xFFFFFFE2 + 0xFFFC × 0xFFFB gives 0xFFFFFFF6.
- R7: In accumulate mode without signed overflow, the flag equals the sign of the new result and the sign-extension word follows that sign. An unsigned carry out of bit 31 has no effect on the flag.
- R8: In accumulate mode with signed overflow, the sign-extension word takes the true sign of the unwrapped sum and the flag is the inverse of that sign.
- R9: A write to address 3 replaces result bits 15:0, and a write to address 4 replaces result bits 31:16. The flag and the sign-extension word are unchanged.
- R10: Operand 1 and the mode are kept across launches. Launches on consecutive cycles each build on the result of the one before.
- R11: Writes to address 5 (sign extension) or address 6 (status) change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address (0 op1 multiply, 1 op1 accumulate, 2 op2, 3 result low, 4 result high, 5 sign extension, 6 status) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address, same map as the write address |
| rd_data | output | 16 | Read data. Status: bit 0 is the flag, bit 1 is the mode |

## Verification
The sharpest collision is a launch that reads the stored result in the same cycle that the previous launch writes it. The bench provokes this with second-operand writes on consecutive cycles in accumulate mode. It also writes a first operand in the cycle just before a launch, so that capture and use are back to back. A scoreboard model tracks the running sum in 64-bit signed arithmetic, from which it decides overflow. Each queued expectation is compared against all four readable registers. A wrong hand-off between operations shows up as a broken chain value, sign word or flag.

// File: rtl/smac_pkg.sv
package smac_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_OP1_MUL = 3'd0,
    A_OP1_MAC = 3'd1,
    A_OP2     = 3'd2,
    A_RES_LO  = 3'd3,
    A_RES_HI  = 3'd4,
    A_SEXT    = 3'd5,
    A_STAT    = 3'd6
  } reg_addr_e;

  typedef enum logic {
    MODE_MUL = 1'b0,
    MODE_MAC = 1'b1
  } mode_e;
endpackage

// File: rtl/smac_mult.sv
module smac_mult #(
  parameter int OP_W = 16,
  localparam int PR_W = 2 * OP_W
) (
  input  logic [OP_W-1:0] a,
  input  logic [OP_W-1:0] b,
  output logic [PR_W-1:0] prod
);
  logic signed [PR_W-1:0] a_ext, b_ext;

  always_comb begin
    a_ext = PR_W'($signed(a));
    b_ext = PR_W'($signed(b));
    prod  = a_ext * b_ext;
  end
endmodule

// File: rtl/smac_accum.sv
module smac_accum #(
  parameter int RES_W = 32,
  parameter int EXT_W = 16
) (
  input  logic             acc_mode,
  input  logic [RES_W-1:0] old_res,
  input  logic [RES_W-1:0] prod,
  output logic [RES_W-1:0] new_res,
  output logic [EXT_W-1:0] new_ext,
  output logic             new_flag
);
  localparam int MSB = RES_W - 1;

  logic [RES_W-1:0] sum;
  logic             ovf;
  logic             true_neg;

  always_comb begin
    sum      = old_res + prod;
    ovf      = acc_mode && (old_res[MSB] == prod[MSB]) && (sum[MSB] != old_res[MSB]);
    new_res  = acc_mode ? sum : prod;
    true_neg = ovf ? old_res[MSB] : new_res[MSB];
    new_ext  = {EXT_W{true_neg}};
    new_flag = ovf ? ~true_neg : new_res[MSB];
  end
endmodule

// File: rtl/smac_unit.sv
module smac_unit
  import smac_pkg::*;
#(
  parameter int OP_W = 16,
  localparam int RES_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [OP_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [OP_W-1:0]   rd_data
);
  localparam int HALVES = RES_W / OP_W;

  logic [OP_W-1:0]  op1_q, op2_q;
  mode_e            mode_q;
  logic [RES_W-1:0] res_q;
  logic [OP_W-1:0]  ext_q;
  logic             flag_q;

  logic [RES_W-1:0] prod, nxt_res;
  logic [OP_W-1:0]  nxt_ext;
  logic             nxt_flag;
  logic             start;

  assign start = wr_en && (wr_addr == A_OP2);

  smac_mult #(.OP_W(OP_W)) u_mult (
    .a    (op1_q),
    .b    (wr_data),
    .prod (prod)
  );

  smac_accum #(.RES_W(RES_W), .EXT_W(OP_W)) u_accum (
    .acc_mode (mode_q == MODE_MAC),
    .old_res  (res_q),
    .prod     (prod),
    .new_res  (nxt_res),
    .new_ext  (nxt_ext),
    .new_flag (nxt_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op1_q  <= '0;
      op2_q  <= '0;
      mode_q <= MODE_MUL;
      ext_q  <= '0;
      flag_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_OP1_MUL: begin op1_q <= wr_data; mode_q <= MODE_MUL; end
        A_OP1_MAC: begin op1_q <= wr_data; mode_q <= MODE_MAC; end
        A_OP2: begin
          op2_q  <= wr_data;
          ext_q  <= nxt_ext;
          flag_q <= nxt_flag;
        end
        default: ;
      endcase
    end
  end

  // Each result half is loaded either from a launch or from a direct preload.
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam logic [ADDR_W-1:0] HALF_ADDR = ADDR_W'(A_RES_LO + h);
    always_ff @(posedge clk) begin
      if (rst)
        res_q[h*OP_W +: OP_W] <= '0;
      else if (start)
        res_q[h*OP_W +: OP_W] <= nxt_res[h*OP_W +: OP_W];
      else if (wr_en && wr_addr == HALF_ADDR)
        res_q[h*OP_W +: OP_W] <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      A_OP1_MUL, A_OP1_MAC: rd_data = op1_q;
      A_OP2:    rd_data = op2_q;
      A_RES_LO: rd_data = res_q[OP_W-1:0];
      A_RES_HI: rd_data = res_q[RES_W-1:OP_W];
      A_SEXT:   rd_data = ext_q;
      A_STAT:   rd_data = {{(OP_W-2){1'b0}}, mode_q, flag_q};
      default:  rd_data = '0;
    endcase
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_q == '0 && ext_q == '0 && !flag_q && mode_q == MODE_MUL));

  // R2
  mode_mac_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_OP1_MAC) |=> mode_q == MODE_MAC);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(res_q) && $stable(ext_q) && $stable(flag_q)));

  // R7
  flag_sign_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> flag_q == res_q[RES_W-1]);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (start && mode_q == MODE_MAC) |=>
      ((flag_q == ext_q[0]) || (res_q[RES_W-1] != $past(res_q[RES_W-1]))));

  // R9
  preload_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_RES_LO) |=>
      (res_q[OP_W-1:0] == $past(wr_data) && $stable(flag_q)));
endmodule

// File: tb/test_smac_unit.sv
module test_smac_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;

  always #10 clk = ~clk;

  smac_unit i_smac_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_res  = '0;
  logic [15:0] m_ext  = '0;
  logic        m_flag = 1'b0;
  logic        m_mac  = 1'b0;
  logic [15:0] m_op1  = '0;

  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] cur;
  string       cur_tag;

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(string tag);
    exp_q.push_back({m_res[15:0], m_res[31:16], m_ext, 14'b0, m_mac, m_flag});
    tag_q.push_back(tag);
  endtask

  task automatic bus_wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic set_op1(bit mac, logic [15:0] v, string tag);
    bus_wr(mac ? 3'd1 : 3'd0, v);
    m_op1 = v; m_mac = mac;
    push(tag);
  endtask

  task automatic launch(logic [15:0] v, string tag);
    longint p, s;
    bus_wr(3'd2, v);
    p = longint'($signed(m_op1)) * longint'($signed(v));
    if (!m_mac) begin
      m_res  = p[31:0];
      m_ext  = (p < 0) ? 16'hFFFF : 16'h0000;
      m_flag = (p < 0);
    end else begin
      s = longint'($signed(m_res)) + p;
      m_res = s[31:0];
      if (s > 64'sd2147483647 || s < -64'sd2147483648) begin
        m_ext  = (s < 0) ? 16'hFFFF : 16'h0000;
        m_flag = !(s < 0);
      end else begin
        m_ext  = m_res[31] ? 16'hFFFF : 16'h0000;
        m_flag = m_res[31];
      end
    end
    push(tag);
  endtask

  task automatic preload(logic [31:0] v, string tag);
    bus_wr(3'd3, v[15:0]);
    bus_wr(3'd4, v[31:16]);
    m_res = v;
    push(tag);
  endtask

  // Monitor: compares every queued expectation through the read port.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      cur_tag = tag_q.pop_front();
      rd_addr = 3'd3; #1 check(cur_tag, "res_lo", rd_data, cur[63:48]);
      rd_addr = 3'd4; #1 check(cur_tag, "res_hi", rd_data, cur[47:32]);
      rd_addr = 3'd5; #1 check(cur_tag, "sext",   rd_data, cur[31:16]);
      rd_addr = 3'd6; #1 check(cur_tag, "status", rd_data, cur[15:0]);
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    push("R1 reset");

    set_op1(1'b0, 16'hFFFA, "R2 mul select");
    launch(16'h0005, "R4 R5 neg product");
    set_op1(1'b1, 16'hFFFC, "R2 mac select");
    launch(16'hFFFB, "R6 R7 sign flag without carry");

    set_op1(1'b0, 16'h7FFF, "R2");
    launch(16'h7FFF, "R4 R5 positive max");
    set_op1(1'b0, 16'h8000, "R2");
    launch(16'h8000, "R4 min times min");

    preload(32'h7FFF_FFF0, "R9 preload");
    set_op1(1'b1, 16'h0100, "R2");
    launch(16'h0100, "R8 positive overflow");

    preload(32'h8000_0000, "R9 preload neg");
    set_op1(1'b1, 16'h8000, "R2");
    launch(16'h0001, "R8 negative overflow");

    preload(32'hFFFF_FFF0, "R9");
    set_op1(1'b1, 16'h0002, "R2");
    launch(16'h000A, "R7 unsigned carry ignored");

    bus_wr(3'd5, 16'h1234);
    push("R11 sext write ignored");
    bus_wr(3'd6, 16'h0000);
    push("R11 status write ignored");

    preload(32'h0, "R9 clear");
    set_op1(1'b1, 16'h0003, "R2");
    launch(16'h0002, "R10 chain step 1");
    launch(16'h0004, "R10 chain step 2");
    launch(16'hFFFB, "R10 R3 chain step 3");

    repeat (4) @(posedge clk);
    push("R3 idle hold");
    repeat (4) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); end
    join_any
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule